// File: doc/BRIEF.md
# Clock Output Enable and Strap Controller

This block is the control core of a multi-output system clock generator. It decides, for every generated clock, whether it runs, is held stopped at a driven low level, or has its driver tri-stated. It also captures the frequency-select, table-select and test-select straps once, at the moment the shared power pin reports that power is good. After that the same pin serves as an asynchronous power-down request. Oscillators, PLLs, dividers and analog drivers live elsewhere. Each output's clock level comes in as a modelled signal, so that every enable change can be placed at a low phase of that clock.

The outputs are split into a CPU group and an SRC group. Two active-low request pins can each be mapped by register bits onto any subset of the SRC outputs. A CPU stop pin halts the CPU outputs except those marked free-running. Every output also has a register enable. From the latched select code and table select, the block reports the selected CPU frequency in kHz.

Top module: `clkgate_strap_ctrl`

## Requirements
- R1: While `straps_ok` is 0, a low on `pgpd_pin` latches `fs_pin`, `tbl_pin` and `tst_pin` into `fs_code`, `tbl_sel` and `test_mode`. The capture takes place at the third rising edge after the fall, and `straps_ok` becomes 1 at that edge. Later changes on the strap pins leave the latched values unchanged.
- R2: `cpu_khz` is looked up from `{tbl_sel, fs_code}`, with `fs_code[2]` as the MSB of the index. Table 0, index 0..7: 266666, 133333, 200000, 166666, 333333, 100000, 400000, 0 (reserved). Table 1, index 0..7: 100000, 200000, 133333, 166666, 200000, 400000, 266666, 333333.
- R3: When the latched test select is 1, every output runs and none is tri-stated, whatever the register, request and stop inputs are. Power-down still overrides test mode.
- R4: `req_a_n` and `req_b_n` pass through two synchronising flops. An SRC output j, at output bit NCPU+j, stops with its driver tri-stated (run 0, hiz 1) when a request pin it is mapped to by `reg_map_a[j]` or `reg_map_b[j]` is high. An SRC output that is not mapped to a high pin keeps running.
- R5: `cpu_halt_n` is synchronised in the same way. While it is low, each CPU output i (bit i, i < NCPU) with `reg_free[i]` = 0 is stopped and driven (run 0, hiz 0). CPU outputs with `reg_free[i]` = 1 and all SRC outputs keep running.
- R6: A `reg_en` bit of 0 stops that output with its driver tri-stated (run 0, hiz 1), at the next rising edge. This takes priority over the stop condition of R5.
- R7: Once `straps_ok` is 1, a high `pgpd_pin` is a power-down. It asynchronously sets a synchroniser, and all outputs read run 0, hiz 0 from the first rising edge after it. After the pin falls again, the outputs restart at the third rising edge.
- R8: The `clk_run` and `clk_hiz` bits of an output change only at a rising edge where that output's `oclk_lvl` bit is low. Otherwise they hold their value.
- R9: Reset (`rst_n` low) clears every run and hiz bit and `straps_ok`. Until the straps are latched, all outputs stay stopped and driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgpd_pin | input | 1 | Active-low power-good before strap capture, active-high power-down after |
| fs_pin | input | 3 | Frequency-select straps {C,B,A} |
| tbl_pin | input | 1 | Frequency-table select strap |
| tst_pin | input | 1 | Test-mode select strap |
| req_a_n | input | 1 | Clock request A, active low |
| req_b_n | input | 1 | Clock request B, active low |
| cpu_halt_n | input | 1 | CPU clock stop, active low |
| reg_en | input | NCPU+NSRC | Per-output register enable |
| reg_map_a | input | NSRC | SRC outputs governed by request A |
| reg_map_b | input | NSRC | SRC outputs governed by request B |
| reg_free | input | NCPU | CPU outputs exempt from CPU stop |
| oclk_lvl | input | NCPU+NSRC | Modelled level of each output clock |
| clk_run | output | NCPU+NSRC | Output runs when 1 |
| clk_hiz | output | NCPU+NSRC | Output driver tri-stated when 1 |
| fs_code | output | 3 | Latched frequency-select code |
| tbl_sel | output | 1 | Latched table select |
| test_mode | output | 1 | Latched test select |
| straps_ok | output | 1 | Straps have been latched |
| cpu_khz | output | 19 | Selected CPU frequency in kHz |

## Verification
Each result has its own latency. Register enables take effect one rising edge after they change. Request pins, CPU stop and the release of power-down take three edges: two synchroniser stages and the gate flop. A power-down assertion takes one edge. Strap capture takes three edges and the first running output a fourth. The bench drives inputs on falling edges, waits exactly that many rising edges and samples on the following falling edge. Where it tests a boundary, it also samples one edge early. The glitch-free rule is tested by raising an output's modelled level before an enable change and confirming that nothing moves until the level falls.

// File: rtl/cks_pkg.sv
package cks_pkg;
  localparam int KHZ_W = 19;

  // CPU frequency in kHz for a latched table select and code (fs[2] is MSB)
  function automatic logic [KHZ_W-1:0] cpu_khz_lookup(input logic tbl, input logic [2:0] fs);
    logic [KHZ_W-1:0] r;
    if (!tbl) begin
      case (fs)
        3'd0: r = 19'd266666;
        3'd1: r = 19'd133333;
        3'd2: r = 19'd200000;
        3'd3: r = 19'd166666;
        3'd4: r = 19'd333333;
        3'd5: r = 19'd100000;
        3'd6: r = 19'd400000;
        default: r = 19'd0;
      endcase
    end else begin
      case (fs)
        3'd0: r = 19'd100000;
        3'd1: r = 19'd200000;
        3'd2: r = 19'd133333;
        3'd3: r = 19'd166666;
        3'd4: r = 19'd200000;
        3'd5: r = 19'd400000;
        3'd6: r = 19'd266666;
        default: r = 19'd333333;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         aset,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n or posedge aset) begin
    if (!rst_n) begin
      s1 <= {W{RST_VAL}};
      q  <= {W{RST_VAL}};
    end else if (aset) begin
      s1 <= '1;
      q  <= '1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/cks_strap_latch.sv
module cks_strap_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_n_s,
  input  logic [2:0] fs_pin,
  input  logic       tbl_pin,
  input  logic       tst_pin,
  output logic [2:0] fs_q,
  output logic       tbl_q,
  output logic       tst_q,
  output logic       done_q
);
  logic capture;
  assign capture = !done_q && !pg_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= '0;
      tbl_q  <= 1'b0;
      tst_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (capture) begin
      fs_q   <= fs_pin;
      tbl_q  <= tbl_pin;
      tst_q  <= tst_pin;
      done_q <= 1'b1;
    end
  end

  a_r1_capture_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (fs_q == $past(fs_pin)) && (tbl_q == $past(tbl_pin)) && (tst_q == $past(tst_pin)));

  a_r1_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> ($stable(fs_q) && $stable(tbl_q) && $stable(tst_q)));
endmodule

// File: rtl/cks_gate_cell.sv
module cks_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic want_run,
  input  logic want_hiz,
  output logic run_q,
  output logic hiz_q
);
  logic upd_ok;
  assign upd_ok = !lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      hiz_q <= 1'b0;
    end else if (upd_ok) begin
      run_q <= want_run;
      hiz_q <= want_hiz;
    end
  end

  // R8: control bits move only across a low phase of the output clock
  a_r8_change_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(run_q) || !$stable(hiz_q)) |-> !$past(lvl));
endmodule

// File: rtl/clkgate_strap_ctrl.sv
module clkgate_strap_ctrl #(
  parameter  int NCPU = 3,
  parameter  int NSRC = 8,
  localparam int NOUT = NCPU + NSRC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pgpd_pin,
  input  logic [2:0]              fs_pin,
  input  logic                    tbl_pin,
  input  logic                    tst_pin,
  input  logic                    req_a_n,
  input  logic                    req_b_n,
  input  logic                    cpu_halt_n,
  input  logic [NOUT-1:0]         reg_en,
  input  logic [NSRC-1:0]         reg_map_a,
  input  logic [NSRC-1:0]         reg_map_b,
  input  logic [NCPU-1:0]         reg_free,
  input  logic [NOUT-1:0]         oclk_lvl,
  output logic [NOUT-1:0]         clk_run,
  output logic [NOUT-1:0]         clk_hiz,
  output logic [2:0]              fs_code,
  output logic                    tbl_sel,
  output logic                    test_mode,
  output logic                    straps_ok,
  output logic [cks_pkg::KHZ_W-1:0] cpu_khz
);
  logic       pg_n_s;
  logic       pd_raw;
  logic       pd_s;
  logic [2:0] ctl_s;
  logic       rqa_off, rqb_off, halt_s, block_all;
  logic [NOUT-1:0] cond_stop, cond_off, want_run, want_hiz;

  cks_sync #(.W(1), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .aset(1'b0), .d(pgpd_pin), .q(pg_n_s));

  assign pd_raw = pgpd_pin & straps_ok;

  cks_sync #(.W(1), .RST_VAL(1'b0)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .aset(pd_raw), .d(pd_raw), .q(pd_s));

  cks_sync #(.W(3), .RST_VAL(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .aset(1'b0),
    .d({req_a_n, req_b_n, cpu_halt_n}), .q(ctl_s));

  cks_strap_latch u_straps (
    .clk(clk), .rst_n(rst_n), .pg_n_s(pg_n_s),
    .fs_pin(fs_pin), .tbl_pin(tbl_pin), .tst_pin(tst_pin),
    .fs_q(fs_code), .tbl_q(tbl_sel), .tst_q(test_mode), .done_q(straps_ok));

  assign rqa_off   = ctl_s[2];
  assign rqb_off   = ctl_s[1];
  assign halt_s    = !ctl_s[0];
  assign block_all = !straps_ok || pd_s;
  assign cpu_khz   = cks_pkg::cpu_khz_lookup(tbl_sel, fs_code);

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    if (i < NCPU) begin : g_cpu
      assign cond_stop[i] = halt_s && !reg_free[i];
      assign cond_off[i]  = 1'b0;

      // R5: a free-running CPU output is not stopped by the halt pin
      a_r5_free_runs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(straps_ok && !pd_s && reg_en[i] && reg_free[i]) && !$past(oclk_lvl[i]))
          |-> clk_run[i]);
    end else begin : g_src
      assign cond_stop[i] = 1'b0;
      assign cond_off[i]  = (reg_map_a[i-NCPU] && rqa_off) || (reg_map_b[i-NCPU] && rqb_off);
    end

    assign want_run[i] = !block_all && (test_mode || (reg_en[i] && !cond_stop[i] && !cond_off[i]));
    assign want_hiz[i] = !block_all && !test_mode && (!reg_en[i] || cond_off[i]);

    cks_gate_cell u_gate (
      .clk(clk), .rst_n(rst_n), .lvl(oclk_lvl[i]),
      .want_run(want_run[i]), .want_hiz(want_hiz[i]),
      .run_q(clk_run[i]), .hiz_q(clk_hiz[i]));

    // R7: power-down leaves every output stopped and driven
    a_r7_pd_stops: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pd_s) && !$past(oclk_lvl[i])) |-> (!clk_run[i] && !clk_hiz[i]));

    // R3: test mode runs every output unless powered down
    a_r3_test_runs: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(straps_ok && !pd_s && test_mode) && !$past(oclk_lvl[i]))
        |-> (clk_run[i] && !clk_hiz[i]));
  end
endmodule

// File: tb/clkgate_strap_ctrl_test.sv
module clkgate_strap_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pgpd_pin = 1'b1;
  logic [2:0] fs_pin = 3'd0;
  logic tbl_pin = 1'b0, tst_pin = 1'b0;
  logic req_a_n = 1'b1, req_b_n = 1'b1, cpu_halt_n = 1'b1;
  logic [10:0] reg_en = '1;
  logic [7:0]  reg_map_a = '0, reg_map_b = '0;
  logic [2:0]  reg_free = '0;
  logic [10:0] oclk_lvl = '0;
  logic [10:0] clk_run, clk_hiz;
  logic [2:0]  fs_code;
  logic tbl_sel, test_mode, straps_ok;
  logic [18:0] cpu_khz;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  clkgate_strap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pgpd_pin(pgpd_pin), .fs_pin(fs_pin),
    .tbl_pin(tbl_pin), .tst_pin(tst_pin), .req_a_n(req_a_n), .req_b_n(req_b_n),
    .cpu_halt_n(cpu_halt_n), .reg_en(reg_en), .reg_map_a(reg_map_a),
    .reg_map_b(reg_map_b), .reg_free(reg_free), .oclk_lvl(oclk_lvl),
    .clk_run(clk_run), .clk_hiz(clk_hiz), .fs_code(fs_code), .tbl_sel(tbl_sel),
    .test_mode(test_mode), .straps_ok(straps_ok), .cpu_khz(cpu_khz));

  // Vectors: enable, map A, map B, free, {req_a_n, req_b_n, cpu_halt_n}, expected run, expected hiz
  localparam logic [10:0] V_EN   [NV] = '{11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FA, 11'h7FE, 11'h3FF};
  localparam logic [7:0]  V_MA   [NV] = '{8'h00, 8'h0F, 8'h0F, 8'h03, 8'h00, 8'h00, 8'h00, 8'h80, 8'h80};
  localparam logic [7:0]  V_MB   [NV] = '{8'h00, 8'h00, 8'hF0, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [2:0]  V_FREE [NV] = '{3'b000, 3'b000, 3'b000, 3'b000, 3'b100, 3'b000, 3'b000, 3'b000, 3'b000};
  localparam logic [2:0]  V_PINS [NV] = '{3'b111, 3'b101, 3'b011, 3'b011, 3'b110, 3'b110, 3'b111, 3'b110, 3'b001};
  localparam logic [10:0] V_RUN  [NV] = '{11'h7FF, 11'h787, 11'h07F, 11'h7EF, 11'h7FC, 11'h7F8, 11'h7FA, 11'h3F8, 11'h3FF};
  localparam logic [10:0] V_HIZ  [NV] = '{11'h000, 11'h078, 11'h780, 11'h010, 11'h000, 11'h000, 11'h005, 11'h401, 11'h400};
  localparam string       V_REQ  [NV] = '{"R4", "R4", "R4", "R4", "R5", "R5", "R6", "R6", "R6"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    fs_pin = 3'b010;
    edges(2);
    rst_n = 1'b1;
    edges(3);
    // R9: stopped and driven before the straps are latched
    chk("R9 run", 32'(clk_run), 32'h0);
    chk("R9 hiz", 32'(clk_hiz), 32'h0);
    chk("R9 straps_ok", 32'(straps_ok), 32'h0);

    // R1: strap capture at the third edge after power-good
    pgpd_pin = 1'b0;
    edges(2);
    chk("R1 not yet", 32'(straps_ok), 32'h0);
    edges(1);
    chk("R1 straps_ok", 32'(straps_ok), 32'h1);
    chk("R1 fs_code", 32'(fs_code), 32'h2);
    chk("R2 table0 idx2", 32'(cpu_khz), 32'd200000);
    fs_pin = 3'b111; tbl_pin = 1'b1; tst_pin = 1'b1;
    edges(1);
    chk("R9 first run", 32'(clk_run), 32'h7FF);
    edges(2);
    chk("R1 hold fs", 32'(fs_code), 32'h2);
    chk("R1 hold test", 32'(test_mode), 32'h0);

    for (int k = 0; k < NV; k++) begin
      reg_en = V_EN[k]; reg_map_a = V_MA[k]; reg_map_b = V_MB[k]; reg_free = V_FREE[k];
      {req_a_n, req_b_n, cpu_halt_n} = V_PINS[k];
      edges(3);
      chk(V_REQ[k], 32'(clk_run), 32'(V_RUN[k]));
      chk(V_REQ[k], 32'(clk_hiz), 32'(V_HIZ[k]));
    end

    // R8: output 0 held while its clock is high
    reg_en = '1; reg_map_a = '0; reg_map_b = '0; reg_free = '0;
    {req_a_n, req_b_n, cpu_halt_n} = 3'b111;
    edges(3);
    oclk_lvl[0] = 1'b1;
    reg_en = 11'h7FE;
    edges(2);
    chk("R8 held run", 32'(clk_run[0]), 32'h1);
    chk("R8 held hiz", 32'(clk_hiz[0]), 32'h0);
    oclk_lvl[0] = 1'b0;
    edges(1);
    chk("R8 applied run", 32'(clk_run[0]), 32'h0);
    chk("R8 applied hiz", 32'(clk_hiz[0]), 32'h1);
    reg_en = '1;
    edges(1);

    // R7: power-down and release
    pgpd_pin = 1'b1;
    edges(1);
    chk("R7 pd run", 32'(clk_run), 32'h0);
    chk("R7 pd hiz", 32'(clk_hiz), 32'h0);
    chk("R1 pd keeps fs", 32'(fs_code), 32'h2);
    pgpd_pin = 1'b0;
    edges(2);
    chk("R7 release early", 32'(clk_run), 32'h0);
    edges(1);
    chk("R7 release", 32'(clk_run), 32'h7FF);

    // R3 and table 1 of R2 after a fresh reset
    rst_n = 1'b0; pgpd_pin = 1'b1;
    fs_pin = 3'b101; tbl_pin = 1'b1; tst_pin = 1'b1;
    reg_en = '0; reg_map_a = '1; req_a_n = 1'b1; cpu_halt_n = 1'b0;
    edges(1);
    chk("R9 reset straps_ok", 32'(straps_ok), 32'h0);
    chk("R9 reset run", 32'(clk_run), 32'h0);
    rst_n = 1'b1;
    edges(2);
    pgpd_pin = 1'b0;
    edges(4);
    chk("R3 test_mode", 32'(test_mode), 32'h1);
    chk("R2 tbl_sel", 32'(tbl_sel), 32'h1);
    chk("R2 table1 idx5", 32'(cpu_khz), 32'd400000);
    chk("R3 run all", 32'(clk_run), 32'h7FF);
    chk("R3 no hiz", 32'(clk_hiz), 32'h0);
    pgpd_pin = 1'b1;
    edges(1);
    chk("R7 pd over test", 32'(clk_run), 32'h0);

    finish_run();
  end
endmodule